// File: doc/BRIEF.md
# Delay-Slot Branch Resolver

This block settles conditional branches for a 32-bit pipeline whose branches carry one delay-slot instruction. Each request carries the decoded primary opcode, the secondary condition field, the source register index, both register operands, the 16-bit branch displacement, and the addresses of the branch and of its delay slot. One cycle after a request is accepted, the block presents the branch outcome, the destination address, a squash flag for the delay slot, the link-register write enable and value, and two diagnostic flags: one for an unrecognised encoding and one for a link form whose source is the link register itself.

Three groups of branch are covered. The first compares two registers for equality or inequality. The second compares one register against zero. The third does the same zero compare but uses the secondary field and may also write a return address. Any of these can be a "likely" form. A likely branch that falls through cancels its delay-slot instruction. A linking branch writes its return address whether or not it is taken.

Requests enter through a valid/ready handshake. Results leave through a second valid/ready handshake, held in a single output register. A request is accepted when `in_valid` and `in_ready` are both high at a clock edge. `in_ready` is high whenever that register is empty or being drained in the same cycle. While a result waits with `out_ready` low, it stays frozen and no new request is taken.

Top module: `branch_resolve_unit`

## Requirements
- R1: `out_target` equals `in_next_pc` plus the displacement. The displacement is `in_offset` sign-extended and multiplied by four. The sum wraps modulo 2^32. It is presented for every legal request, taken or not.
- R2: Opcodes 000100 (equal), 000101 (not equal), 010100 (equal, likely) and 010101 (not equal, likely) are taken when `in_opa` and `in_opb` meet the condition.
- R3: The zero compares treat `in_opa` as a signed value and use these encodings:
  - opcode 000110: taken when `in_opa` <= 0;
  - opcode 000111: taken when `in_opa` > 0;
  - opcodes 010110 and 010111: the likely forms of the two above;
  - all four of these need `in_rt` = 00000;
  - opcode 000001 decodes `in_rt` as follows: 00000 taken when < 0, 00001 when >= 0, 00010 and 00011 are the likely forms of these, 10000 and 10001 are the linking forms, and 10010 and 10011 are the linking likely forms.
- R4: `out_squash` is 1 exactly when a likely form is not taken. A non-likely form, or any taken branch, gives `out_squash` = 0.
- R5: The four linking forms (opcode 000001 with `in_rt` 100xx) set `out_link_we` = 1 whether taken or not. Every other encoding gives 0. `out_link_val` always equals `in_pc` + 8.
- R6: `out_unpredictable` is 1 only for a linking form whose `in_rs` is 31.
- R7: Any other opcode/condition-field combination gives `out_illegal` = 1 with taken, squash, link write and unpredictable all 0. A legal encoding gives `out_illegal` = 0.
- R8: A request accepted at an edge produces `out_valid` = 1 and its results after that same edge.
- R9: `in_ready` = !`out_valid` || `out_ready`. While `out_valid` is 1 and `out_ready` is 0, all result outputs hold their values.
- R10: While `rst_n` is low and after its release, `out_valid` is 0 until the first request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be accepted |
| in_opcode | input | 6 | Primary opcode |
| in_rt | input | 5 | Secondary condition field |
| in_rs | input | 5 | Source register index |
| in_opa | input | 32 | First operand |
| in_opb | input | 32 | Second operand |
| in_offset | input | 16 | Word displacement |
| in_pc | input | 32 | Branch instruction address |
| in_next_pc | input | 32 | Delay-slot instruction address |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_taken | output | 1 | Branch taken |
| out_target | output | 32 | Destination address |
| out_squash | output | 1 | Cancel the delay-slot instruction |
| out_link_we | output | 1 | Write the link register |
| out_link_val | output | 32 | Return address |
| out_unpredictable | output | 1 | Linking form sourced from register 31 |
| out_illegal | output | 1 | Unrecognised encoding |

## Verification
The bench aims at the sign boundaries of the zero compares, the most negative value, and zero itself. A resolver that compared unsigned, or swapped a strict test for an inclusive one, would flip the outcome on those operands. Likely forms are run both ways, because a design that squashed on taken branches or cleared squash on fall-through would cancel the wrong instruction. Linking forms that fall through are included to expose a link write gated by the outcome. The bench also covers a negative displacement, an address that wraps, and a blocked result with its inputs changed underneath it. These catch a missing sign extension, the wrong base address, and a result register that is overwritten while stalled.

// File: rtl/brres_pkg.sv
package brres_pkg;
  typedef enum logic [2:0] {
    CMP_EQ, CMP_NE, CMP_LEZ, CMP_GTZ, CMP_LTZ, CMP_GEZ
  } cmp_e;

  typedef struct packed {
    logic legal;
    logic likely;
    logic link;
    cmp_e cmp;
  } brdec_t;

  localparam logic [5:0] OPC_ZERO_GRP = 6'b000001;
endpackage

// File: rtl/brres_decode.sv
module brres_decode
  import brres_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [4:0] rt,
  output brdec_t     dec
);
  always_comb begin
    dec = '{legal: 1'b0, likely: 1'b0, link: 1'b0, cmp: CMP_EQ};
    if (opcode == OPC_ZERO_GRP) begin
      // rt: bit4 link, bit1 likely, bit0 selects >=0 over <0, bits 3:2 zero
      dec.legal  = (rt[3:2] == 2'b00);
      dec.link   = rt[4] & dec.legal;
      dec.likely = rt[1];
      dec.cmp    = rt[0] ? CMP_GEZ : CMP_LTZ;
    end else if (!opcode[5] && opcode[3:2] == 2'b01) begin
      dec.likely = opcode[4];
      unique case (opcode[1:0])
        2'b00: dec.cmp = CMP_EQ;
        2'b01: dec.cmp = CMP_NE;
        2'b10: dec.cmp = CMP_LEZ;
        default: dec.cmp = CMP_GTZ;
      endcase
      dec.legal = !opcode[1] || (rt == 5'b00000);
    end
  end
endmodule

// File: rtl/brres_cond.sv
module brres_cond
  import brres_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  cmp_e            cmp,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  output logic            hit
);
  logic neg, zero, same;
  assign neg  = opa[XLEN-1];
  assign zero = (opa == '0);
  assign same = (opa == opb);

  always_comb begin
    unique case (cmp)
      CMP_EQ:  hit = same;
      CMP_NE:  hit = !same;
      CMP_LEZ: hit = neg || zero;
      CMP_GTZ: hit = !neg && !zero;
      CMP_LTZ: hit = neg;
      CMP_GEZ: hit = !neg;
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/brres_addr.sv
module brres_addr #(
  parameter int XLEN = 32,
  parameter int OFFW = 16,
  parameter int INSN_BYTES_LOG2 = 2
) (
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] next_pc,
  input  logic [OFFW-1:0] offset,
  output logic [XLEN-1:0] target,
  output logic [XLEN-1:0] link_val
);
  localparam int EXTW = XLEN - OFFW - INSN_BYTES_LOG2;
  localparam logic [XLEN-1:0] LINK_STEP = XLEN'(2 << INSN_BYTES_LOG2);

  logic [XLEN-1:0] disp;
  generate
    if (EXTW > 0) begin : g_ext
      assign disp = {{EXTW{offset[OFFW-1]}}, offset, {INSN_BYTES_LOG2{1'b0}}};
    end else begin : g_trunc
      logic [OFFW+INSN_BYTES_LOG2-1:0] wide;
      assign wide = {offset, {INSN_BYTES_LOG2{1'b0}}};
      assign disp = wide[XLEN-1:0];
    end
  endgenerate

  assign target   = next_pc + disp;
  assign link_val = pc + LINK_STEP;
endmodule

// File: rtl/branch_resolve_unit.sv
module branch_resolve_unit
  import brres_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int OFFW = 16,
  parameter int REGW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [5:0]      in_opcode,
  input  logic [4:0]      in_rt,
  input  logic [REGW-1:0] in_rs,
  input  logic [XLEN-1:0] in_opa,
  input  logic [XLEN-1:0] in_opb,
  input  logic [OFFW-1:0] in_offset,
  input  logic [XLEN-1:0] in_pc,
  input  logic [XLEN-1:0] in_next_pc,
  output logic            out_valid,
  input  logic            out_ready,
  output logic            out_taken,
  output logic [XLEN-1:0] out_target,
  output logic            out_squash,
  output logic            out_link_we,
  output logic [XLEN-1:0] out_link_val,
  output logic            out_unpredictable,
  output logic            out_illegal
);
  localparam logic [REGW-1:0] LINK_IDX = '1;

  brdec_t          dec;
  logic            hit;
  logic [XLEN-1:0] tgt_n, link_n;
  logic            taken_n, squash_n, lwe_n, unp_n, accept;

  brres_decode u_dec (.opcode(in_opcode), .rt(in_rt), .dec(dec));

  brres_cond #(.XLEN(XLEN)) u_cond (
    .cmp(dec.cmp), .opa(in_opa), .opb(in_opb), .hit(hit)
  );

  brres_addr #(.XLEN(XLEN), .OFFW(OFFW)) u_addr (
    .pc(in_pc), .next_pc(in_next_pc), .offset(in_offset),
    .target(tgt_n), .link_val(link_n)
  );

  assign taken_n  = dec.legal && hit;
  assign squash_n = dec.legal && dec.likely && !hit;
  assign lwe_n    = dec.legal && dec.link;
  assign unp_n    = lwe_n && (in_rs == LINK_IDX);

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_taken         <= 1'b0;
      out_target        <= '0;
      out_squash        <= 1'b0;
      out_link_we       <= 1'b0;
      out_link_val      <= '0;
      out_unpredictable <= 1'b0;
      out_illegal       <= 1'b0;
    end else if (accept) begin
      out_taken         <= taken_n;
      out_target        <= tgt_n;
      out_squash        <= squash_n;
      out_link_we       <= lwe_n;
      out_link_val      <= link_n;
      out_unpredictable <= unp_n;
      out_illegal       <= !dec.legal;
    end
  end
endmodule

// File: rtl/branch_resolve_chk.sv
module branch_resolve_chk #(
  parameter int XLEN = 32,
  parameter int OFFW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic [OFFW-1:0] in_offset,
  input logic [XLEN-1:0] in_pc,
  input logic [XLEN-1:0] in_next_pc,
  input logic            out_valid,
  input logic            out_ready,
  input logic            out_taken,
  input logic [XLEN-1:0] out_target,
  input logic            out_squash,
  input logic            out_link_we,
  input logic [XLEN-1:0] out_link_val,
  input logic            out_unpredictable,
  input logic            out_illegal
);
  logic [XLEN-1:0] disp;
  assign disp = XLEN'({{(XLEN-OFFW){in_offset[OFFW-1]}}, in_offset} <<< 2);

  AST_TARGET_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_target == $past(in_next_pc + disp)); // R1
  AST_NO_SQUASH_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_taken |-> !out_squash); // R4
  AST_LINK_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_link_val == $past(in_pc) + XLEN'(8)); // R5
  AST_UNPRED_ON_LINK: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_unpredictable |-> out_link_we); // R6
  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_illegal |-> !out_taken && !out_squash && !out_link_we && !out_unpredictable); // R7
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid); // R8
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_taken) && $stable(out_target) && $stable(out_squash) && $stable(out_link_we) && $stable(out_link_val) && $stable(out_illegal)); // R9
  AST_READY_RULE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R9
endmodule

bind branch_resolve_unit branch_resolve_chk #(.XLEN(XLEN), .OFFW(OFFW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_offset(in_offset), .in_pc(in_pc), .in_next_pc(in_next_pc),
  .out_valid(out_valid), .out_ready(out_ready), .out_taken(out_taken),
  .out_target(out_target), .out_squash(out_squash), .out_link_we(out_link_we),
  .out_link_val(out_link_val), .out_unpredictable(out_unpredictable),
  .out_illegal(out_illegal)
);

// File: tb/tb_branch_resolve_unit.sv
`timescale 1ns/1ps
module tb_branch_resolve_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b1;
  logic [5:0] in_opcode = '0;
  logic [4:0] in_rt = '0, in_rs = '0;
  logic [31:0] in_opa = '0, in_opb = '0, in_pc = '0, in_next_pc = '0;
  logic [15:0] in_offset = '0;
  logic out_taken, out_squash, out_link_we, out_unpredictable, out_illegal;
  logic [31:0] out_target, out_link_val;

  branch_resolve_unit dut (.*);

  typedef struct packed {
    logic [5:0]  op;
    logic [4:0]  rt;
    logic [4:0]  rs;
    logic [31:0] a;
    logic [31:0] b;
    logic [15:0] off;
    logic [31:0] pc;
    logic [31:0] npc;
    logic tk, sq, lw, up, il;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    // R2 equal taken
    '{6'b000100,5'd0,5'd1,32'd5,32'd5,16'h0010,32'h1000,32'h1004,1'b1,1'b0,1'b0,1'b0,1'b0,4'd2},
    '{6'b000100,5'd0,5'd1,32'd5,32'd6,16'h0010,32'h1000,32'h1004,1'b0,1'b0,1'b0,1'b0,1'b0,4'd2},
    '{6'b000101,5'd0,5'd1,32'hFFFFFFFF,32'd1,16'h0004,32'h2000,32'h2004,1'b1,1'b0,1'b0,1'b0,1'b0,4'd2},
    // R4 likely forms falling through
    '{6'b010100,5'd0,5'd1,32'd1,32'd2,16'h0004,32'h2000,32'h2004,1'b0,1'b1,1'b0,1'b0,1'b0,4'd4},
    '{6'b010101,5'd0,5'd1,32'd7,32'd7,16'h0004,32'h2000,32'h2004,1'b0,1'b1,1'b0,1'b0,1'b0,4'd4},
    // R3 zero compares
    '{6'b000110,5'd0,5'd2,32'd0,32'd9,16'h0008,32'h3000,32'h3004,1'b1,1'b0,1'b0,1'b0,1'b0,4'd3},
    '{6'b000111,5'd0,5'd2,32'd0,32'd9,16'h0008,32'h3000,32'h3004,1'b0,1'b0,1'b0,1'b0,1'b0,4'd3},
    '{6'b000111,5'd0,5'd2,32'h7FFFFFFF,32'd0,16'h0008,32'h3000,32'h3004,1'b1,1'b0,1'b0,1'b0,1'b0,4'd3},
    '{6'b010110,5'd0,5'd2,32'd1,32'd0,16'h0008,32'h3000,32'h3004,1'b0,1'b1,1'b0,1'b0,1'b0,4'd3},
    '{6'b010111,5'd0,5'd2,32'h80000000,32'd0,16'h0008,32'h3000,32'h3004,1'b0,1'b1,1'b0,1'b0,1'b0,4'd3},
    '{6'b000001,5'b00000,5'd3,32'h80000000,32'd0,16'h0001,32'h4000,32'h4004,1'b1,1'b0,1'b0,1'b0,1'b0,4'd3},
    '{6'b000001,5'b00001,5'd3,32'd0,32'd0,16'h0001,32'h4000,32'h4004,1'b1,1'b0,1'b0,1'b0,1'b0,4'd3},
    '{6'b000001,5'b00010,5'd3,32'd0,32'd0,16'h0001,32'h4000,32'h4004,1'b0,1'b1,1'b0,1'b0,1'b0,4'd4},
    '{6'b000001,5'b00011,5'd3,32'hFFFFFFFB,32'd0,16'h0001,32'h4000,32'h4004,1'b0,1'b1,1'b0,1'b0,1'b0,4'd4},
    // R5 linking forms, taken or not
    '{6'b000001,5'b10000,5'd4,32'd5,32'd0,16'h0002,32'h5000,32'h5004,1'b0,1'b0,1'b1,1'b0,1'b0,4'd5},
    // R6 link with rs 31
    '{6'b000001,5'b10001,5'd31,32'd5,32'd0,16'h0002,32'h5000,32'h5004,1'b1,1'b0,1'b1,1'b1,1'b0,4'd6},
    '{6'b000001,5'b10010,5'd4,32'hFFFFFFFF,32'd0,16'h0002,32'h5000,32'h5004,1'b1,1'b0,1'b1,1'b0,1'b0,4'd5},
    '{6'b000001,5'b10011,5'd4,32'hFFFFFFFF,32'd0,16'h0002,32'h5000,32'h5004,1'b0,1'b1,1'b1,1'b0,1'b0,4'd5},
    // R7 illegal encodings
    '{6'b000110,5'b00001,5'd31,32'd0,32'd0,16'h0002,32'h6000,32'h6004,1'b0,1'b0,1'b0,1'b0,1'b1,4'd7},
    '{6'b000001,5'b00100,5'd31,32'd0,32'd0,16'h0002,32'h6000,32'h6004,1'b0,1'b0,1'b0,1'b0,1'b1,4'd7},
    '{6'b000000,5'b00000,5'd0,32'd0,32'd0,16'h0002,32'h6000,32'h6004,1'b0,1'b0,1'b0,1'b0,1'b1,4'd7},
    // R1 negative displacement and wraparound
    '{6'b000100,5'd0,5'd1,32'd3,32'd3,16'h8000,32'h0003FFFC,32'h00040000,1'b1,1'b0,1'b0,1'b0,1'b0,4'd1},
    '{6'b000100,5'd0,5'd1,32'd3,32'd3,16'h0002,32'hFFFFFFF8,32'hFFFFFFFC,1'b1,1'b0,1'b0,1'b0,1'b0,4'd1},
    // R6 non-link with rs 31 stays predictable
    '{6'b000101,5'd0,5'd31,32'd1,32'd2,16'h0001,32'h7000,32'h7004,1'b1,1'b0,1'b0,1'b0,1'b0,4'd6}
  };

  int checks = 0, fails = 0;

  function automatic logic [31:0] exp_tgt(vec_t v);
    return v.npc + {{14{v.off[15]}}, v.off, 2'b00};
  endfunction

  task automatic drive(vec_t v);
    in_opcode = v.op; in_rt = v.rt; in_rs = v.rs; in_opa = v.a; in_opb = v.b;
    in_offset = v.off; in_pc = v.pc; in_next_pc = v.npc;
  endtask

  task automatic check_vec(vec_t v, string tag);
    logic [31:0] et;
    et = exp_tgt(v);
    checks++;
    if (out_valid !== 1'b1 || out_taken !== v.tk || out_squash !== v.sq ||
        out_link_we !== v.lw || out_unpredictable !== v.up || out_illegal !== v.il ||
        out_link_val !== v.pc + 32'd8 || (!v.il && out_target !== et)) begin
      fails++;
      $display("FAIL R%0d %s: got v=%b tk=%b sq=%b lw=%b up=%b il=%b tgt=%h lnk=%h exp v=1 tk=%b sq=%b lw=%b up=%b il=%b tgt=%h lnk=%h",
        v.req, tag, out_valid, out_taken, out_squash, out_link_we, out_unpredictable,
        out_illegal, out_target, out_link_val, v.tk, v.sq, v.lw, v.up, v.il, et, v.pc + 32'd8);
    end
  endtask

  task automatic check_bit(logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", what, act, exp);
    end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_bit(out_valid, 1'b0, "R10 out_valid in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_bit(out_valid, 1'b0, "R10 out_valid after reset");
    check_bit(in_ready, 1'b1, "R9 in_ready when empty");

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      in_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      check_vec(VECS[i], $sformatf("vector %0d", i));   // R8 one-cycle latency
    end
    @(negedge clk);
    check_bit(out_valid, 1'b0, "R8 out_valid drops when drained");

    // R9 back-pressure: result held, no new accept
    out_ready = 1'b0;
    drive(VECS[15]);
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check_vec(VECS[15], "R9 stalled capture");
    check_bit(in_ready, 1'b0, "R9 in_ready low while blocked");
    drive(VECS[18]);
    @(posedge clk);
    @(negedge clk);
    check_vec(VECS[15], "R9 held under stall");
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check_vec(VECS[18], "R9 next request after release");

    // R10 reset clears a pending result
    out_ready = 1'b0;
    drive(VECS[0]);
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check_bit(out_valid, 1'b0, "R10 reset clears pending result");
    rst_n = 1'b1;
    out_ready = 1'b1;
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule